// File: doc/BRIEF.md
# Bidirectional Ring Data Interconnect

This block joins a fixed set of on-chip nodes (twelve by default: a control core, eight vector cores, a memory controller and two I/O ports) through four unidirectional rings. Two rings move traffic toward increasing node numbers and two move it toward decreasing node numbers. Each ring slot carries one 128-bit (16-byte) payload with its source and destination ids. The rings move forward by one stop on every second core clock cycle, so ring movement runs at half the core rate.

Every node has an inject port and a set of eject ports, one per ring. An injected packet goes in the direction with the smaller hop count, so no packet travels more than half the ring. Within that direction it takes the first lane whose slot at the injecting stop is not held by passing traffic. Traffic already on a ring always keeps its slot. An injector whose lanes are both taken sees ready low and waits. A packet leaves the ring at its destination stop. It then appears for one core cycle on that node's eject port for the ring it used, together with its source id.

Top module: `ring_interconnect`

## Requirements
- R1: While reset is held and in the first cycle after it, every eject valid and every inject ready is low, and all ring slots are empty.
- R2: Ring movement and injection acceptance happen only in advance cycles. These alternate with idle cycles. The first advance cycle is the second cycle after reset is released. In idle cycles inject ready is low even when inject valid is high.
- R3: With d = (dst − src) mod N, a packet uses a clockwise ring (index 0 or 1, toward higher node ids, wrapping from N−1 to 0) when d ≤ N/2, including the tie d = N/2. Otherwise it uses a counter-clockwise ring (index 2 or 3). The hop count is d for clockwise and N−d for counter-clockwise.
- R4: A packet accepted at clock edge E appears on its destination's eject port in the cycle that follows edge E + 2·hops.
- R5: Within the chosen direction, the lower lane (ring 0 or ring 2) is used when its slot at the injecting stop is free, and the upper lane (ring 1 or ring 3) is used otherwise.
- R6: A slot held by a passing packet not addressed to the stop is never taken by injection. When both lanes of the chosen direction are held, ready is low and the request stays pending. A slot whose packet leaves at this stop is free for injection in the same advance cycle.
- R7: An eject valid is high for exactly one core cycle per delivered packet, on the port for the ring the packet used. It carries the original source id and payload.
- R8: A request whose destination equals its source, or is not below N, is consumed in an advance cycle with ready and error both high, and nothing is delivered for it.
- R9: Requests from all nodes in the same advance cycle are all accepted when lanes are free, and all of them are delivered, including those that cross the wrap from node N−1 to node 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| inj_valid | input | NODES | Per-node inject request |
| inj_dst | input | NODES×ID_W | Per-node destination id |
| inj_data | input | NODES×DATA_W | Per-node payload |
| inj_ready | output | NODES | Request accepted at the coming edge |
| inj_err | output | NODES | Request consumed as invalid (with ready) |
| ej_valid | output | NODES×4 | Delivery pulse per node and ring |
| ej_src | output | NODES×4×ID_W | Source id of the delivered packet |
| ej_data | output | NODES×4×DATA_W | Payload of the delivered packet |

## Verification
Single packets go short distances each way and across the half-ring tie. These tell the direction rule apart from a plain clockwise ring and check the tie-break and the hop-based delivery cycle. Staggered injections from adjacent nodes stack passing traffic on both lanes of one direction, in each direction. This separates lane choice, transit priority and the stall-then-retry path. Every node then injects at once, first to its neighbour and then a second wave in the next advance cycle. These waves show that a slot freed by delivery can be reused at once and that traffic crossing the ring's wrap point is delivered. Invalid destinations are sent to confirm they produce an error flag and no delivery.

// File: rtl/ring_pkg.sv
package ring_pkg;

    // Ring count and split by direction
    localparam int LANES         = 4;
    localparam int LANES_PER_DIR = 2;

    typedef enum logic {
        DIR_CW  = 1'b0,
        DIR_CCW = 1'b1
    } dir_e;

    // First ring index used by a direction
    function automatic int lane_base(input dir_e d);
        return (d == DIR_CW) ? 0 : LANES_PER_DIR;
    endfunction

endpackage

// File: rtl/ring_route.sv
module ring_route
    import ring_pkg::*;
#(
    parameter int NODES = 12,
    parameter int ID_W  = 4
) (
    input  logic [ID_W-1:0] src,
    input  logic [ID_W-1:0] dst,
    output logic            bad,
    output dir_e            dir,
    output logic [ID_W-1:0] hops
);

    localparam logic [ID_W:0] N_W  = (ID_W+1)'(NODES);
    localparam logic [ID_W:0] HALF = (ID_W+1)'(NODES / 2);

    logic [ID_W:0] diff;
    logic [ID_W:0] back;

    always_comb begin
        bad = (dst == src) || ({1'b0, dst} >= N_W);
        if (dst >= src) begin
            diff = {1'b0, dst} - {1'b0, src};
        end else begin
            diff = {1'b0, dst} + N_W - {1'b0, src};
        end
        back = N_W - diff;
        // ties go clockwise
        if (diff <= HALF) begin
            dir  = DIR_CW;
            hops = diff[ID_W-1:0];
        end else begin
            dir  = DIR_CCW;
            hops = back[ID_W-1:0];
        end
    end

endmodule

// File: rtl/ring_stop.sv
module ring_stop
    import ring_pkg::*;
#(
    parameter int NODES = 12,
    parameter int ID_W  = 4,
    parameter int ID    = 0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       step,
    input  logic [LANES-1:0]           arr_vld,
    input  logic [LANES-1:0][ID_W-1:0] arr_dst,
    input  logic                       inj_valid,
    input  logic [ID_W-1:0]            inj_dst,
    output logic [LANES-1:0]           pass,
    output logic [LANES-1:0]           drop,
    output logic [LANES-1:0]           ins,
    output logic                       inj_ready,
    output logic                       inj_err
);

    localparam logic [ID_W-1:0] MY_ID = ID_W'(ID);
    localparam logic [ID_W-1:0] HALF  = ID_W'(NODES / 2);

    logic            rt_bad;
    dir_e            rt_dir;
    logic [ID_W-1:0] rt_hops;

    ring_route #(
        .NODES (NODES),
        .ID_W  (ID_W)
    ) u_route (
        .src  (MY_ID),
        .dst  (inj_dst),
        .bad  (rt_bad),
        .dir  (rt_dir),
        .hops (rt_hops)
    );

    // Arrivals: leave here, or keep moving with priority over injection
    always_comb begin
        for (int r = 0; r < LANES; r++) begin
            drop[r] = arr_vld[r] && (arr_dst[r] == MY_ID);
            pass[r] = arr_vld[r] && !drop[r];
        end
    end

    // Injection: lower lane of the chosen direction first
    always_comb begin
        ins       = '0;
        inj_ready = 1'b0;
        inj_err   = 1'b0;
        if (step && inj_valid) begin
            if (rt_bad) begin
                inj_ready = 1'b1;
                inj_err   = 1'b1;
            end else begin
                for (int k = 0; k < LANES_PER_DIR; k++) begin
                    if (!inj_ready && !pass[lane_base(rt_dir) + k]) begin
                        ins[lane_base(rt_dir) + k] = 1'b1;
                        inj_ready                  = 1'b1;
                    end
                end
            end
        end
    end

    // R5
    lane_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ins));

    // R6
    ins_over_transit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins & pass) == '0);

    // R3
    hop_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ins) |-> (rt_hops <= HALF) && (rt_hops != '0));

    // R8
    err_no_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inj_err |-> (ins == '0) && inj_ready);

endmodule

// File: rtl/ring_interconnect.sv
module ring_interconnect
    import ring_pkg::*;
#(
    parameter int NODES  = 12,
    parameter int DATA_W = 128,
    localparam int ID_W  = $clog2(NODES)
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [NODES-1:0]                        inj_valid,
    input  logic [NODES-1:0][ID_W-1:0]              inj_dst,
    input  logic [NODES-1:0][DATA_W-1:0]            inj_data,
    output logic [NODES-1:0]                        inj_ready,
    output logic [NODES-1:0]                        inj_err,
    output logic [NODES-1:0][LANES-1:0]             ej_valid,
    output logic [NODES-1:0][LANES-1:0][ID_W-1:0]   ej_src,
    output logic [NODES-1:0][LANES-1:0][DATA_W-1:0] ej_data
);

    typedef struct packed {
        logic              vld;
        logic [ID_W-1:0]   src;
        logic [ID_W-1:0]   dst;
        logic [DATA_W-1:0] data;
    } pkt_t;

    typedef struct packed {
        logic                               ph;
        logic [LANES-1:0][NODES-1:0][$bits(pkt_t)-1:0] slot;
        logic [NODES-1:0][LANES-1:0][$bits(pkt_t)-1:0] ej;
    } st_t;

    st_t st_d, st_q;

    logic step;
    assign step = st_q.ph;

    // Downstream stop of stop i on ring r
    function automatic int nxt(input int i, input int r);
        if (r < LANES_PER_DIR) return (i + 1) % NODES;
        return (i + NODES - 1) % NODES;
    endfunction

    logic [NODES-1:0][LANES-1:0]           arr_vld;
    logic [NODES-1:0][LANES-1:0][ID_W-1:0] arr_dst;
    logic [NODES-1:0][LANES-1:0]           pass_w;
    logic [NODES-1:0][LANES-1:0]           drop_w;
    logic [NODES-1:0][LANES-1:0]           ins_w;

    always_comb begin
        for (int i = 0; i < NODES; i++) begin
            for (int r = 0; r < LANES; r++) begin
                pkt_t p;
                p = pkt_t'(st_q.slot[r][i]);
                arr_vld[i][r] = p.vld;
                arr_dst[i][r] = p.dst;
            end
        end
    end

    for (genvar g = 0; g < NODES; g++) begin : g_stop
        ring_stop #(
            .NODES (NODES),
            .ID_W  (ID_W),
            .ID    (g)
        ) u_stop (
            .clk       (clk),
            .rst_n     (rst_n),
            .step      (step),
            .arr_vld   (arr_vld[g]),
            .arr_dst   (arr_dst[g]),
            .inj_valid (inj_valid[g]),
            .inj_dst   (inj_dst[g]),
            .pass      (pass_w[g]),
            .drop      (drop_w[g]),
            .ins       (ins_w[g]),
            .inj_ready (inj_ready[g]),
            .inj_err   (inj_err[g])
        );
    end

    // Next-state: ring movement on advance cycles, one-cycle eject pulses
    always_comb begin
        st_d    = st_q;
        st_d.ph = ~st_q.ph;
        for (int i = 0; i < NODES; i++) begin
            for (int r = 0; r < LANES; r++) begin
                pkt_t cur;
                pkt_t nw;
                cur            = pkt_t'(st_q.slot[r][i]);
                nw.vld         = 1'b1;
                nw.src         = ID_W'(i);
                nw.dst         = inj_dst[i];
                nw.data        = inj_data[i];
                st_d.ej[i][r]  = '0;
                if (step) begin
                    if (drop_w[i][r]) begin
                        st_d.ej[i][r] = cur;
                    end
                    if (pass_w[i][r]) begin
                        st_d.slot[r][nxt(i, r)] = cur;
                    end else if (ins_w[i][r]) begin
                        st_d.slot[r][nxt(i, r)] = nw;
                    end else begin
                        st_d.slot[r][nxt(i, r)] = '0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        for (int i = 0; i < NODES; i++) begin
            for (int r = 0; r < LANES; r++) begin
                pkt_t e;
                e             = pkt_t'(st_q.ej[i][r]);
                ej_valid[i][r] = e.vld;
                ej_src[i][r]   = e.src;
                ej_data[i][r]  = e.data;
            end
        end
    end

    // R2
    ready_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|inj_ready) |=> !(|inj_ready));

    // R7
    eject_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ej_valid) |=> !(|ej_valid));

    // R2
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(st_q.slot));

    for (genvar g = 0; g < NODES; g++) begin : g_ejchk
        for (genvar h = 0; h < LANES; h++) begin : g_lane
            // R7
            ej_not_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ej_valid[g][h] |-> (ej_src[g][h] != ID_W'(g)));
        end
    end

endmodule

// File: tb/ring_interconnect_tb.sv
`timescale 1ns/100ps
module ring_interconnect_tb;

    localparam int N  = 12;
    localparam int DW = 128;
    localparam int IW = 4;
    localparam int L  = 4;

    logic                          clk = 1'b0;
    logic                          rst_n = 1'b0;
    logic [N-1:0]                  inj_valid = '0;
    logic [N-1:0][IW-1:0]          inj_dst = '0;
    logic [N-1:0][DW-1:0]          inj_data = '0;
    logic [N-1:0]                  inj_ready;
    logic [N-1:0]                  inj_err;
    logic [N-1:0][L-1:0]           ej_valid;
    logic [N-1:0][L-1:0][IW-1:0]   ej_src;
    logic [N-1:0][L-1:0][DW-1:0]   ej_data;

    ring_interconnect #(.NODES(N), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .inj_valid(inj_valid), .inj_dst(inj_dst), .inj_data(inj_data),
        .inj_ready(inj_ready), .inj_err(inj_err),
        .ej_valid(ej_valid), .ej_src(ej_src), .ej_data(ej_data)
    );

    always #2.5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit ph_tb = 1'b0;
    bit done  = 1'b0;

    always @(posedge clk) begin
        cyc   <= cyc + 1;
        ph_tb <= rst_n ? ~ph_tb : 1'b0;
    end

    typedef struct {
        int          dst;
        int          ring;
        int          src;
        logic [DW-1:0] data;
        int          due;
    } exp_t;
    exp_t q[$];

    bit            armed   [N];
    bit            exp_rdy [N];
    bit            exp_err [N];
    int            exp_ring[N];
    int            exp_hops[N];
    string         tag     [N];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic arm(input int node, input int dst, input logic [DW-1:0] data,
                       input int lane_sel, input bit rdy, input bit err, input string t);
        int d;
        bit cw;
        d              = ((dst - node) % N + N) % N;
        cw             = (d <= N / 2);
        inj_valid[node] = 1'b1;
        inj_dst[node]   = IW'(dst);
        inj_data[node]  = data;
        armed[node]     = 1'b1;
        exp_rdy[node]   = rdy;
        exp_err[node]   = err;
        exp_ring[node]  = (cw ? 0 : 2) + lane_sel;
        exp_hops[node]  = cw ? d : N - d;
        tag[node]       = t;
    endtask

    task automatic do_step();
        if (!ph_tb) begin
            #1;
            for (int n = 0; n < N; n++)
                if (armed[n]) chk(inj_ready[n] == 1'b0, "R2", "ready in idle cycle", inj_ready[n], 0);
            @(negedge clk);
        end
        #1;
        for (int n = 0; n < N; n++) begin
            if (armed[n]) begin
                chk(inj_ready[n] == exp_rdy[n], tag[n], $sformatf("ready node %0d", n), inj_ready[n], exp_rdy[n]);
                chk(inj_err[n] == exp_err[n], tag[n], $sformatf("err node %0d", n), inj_err[n], exp_err[n]);
            end
        end
        @(negedge clk);
        for (int n = 0; n < N; n++) begin
            if (armed[n] && exp_rdy[n]) begin
                if (!exp_err[n])
                    q.push_back('{dst: int'(inj_dst[n]), ring: exp_ring[n], src: n,
                                  data: inj_data[n], due: cyc + 2 * exp_hops[n]});
                inj_valid[n] = 1'b0;
                armed[n]     = 1'b0;
            end
        end
    endtask

    task automatic drain();
        for (int k = 0; k < 40 && q.size() != 0; k++) @(negedge clk);
        chk(q.size() == 0, "R4", "undelivered packets", q.size(), 0);
        q.delete();
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < N; i++) begin
                for (int r = 0; r < L; r++) begin
                    if (ej_valid[i][r]) begin
                        int hit;
                        hit = -1;
                        for (int k = 0; k < q.size(); k++)
                            if (hit < 0 && q[k].dst == i && q[k].src == int'(ej_src[i][r])
                                && q[k].data == ej_data[i][r]) hit = k;
                        if (hit < 0) begin
                            chk(1'b0, "R7", $sformatf("unexpected eject node %0d ring %0d src", i, r),
                                ej_src[i][r], -1);
                        end else begin
                            chk(q[hit].ring == r, "R5", $sformatf("eject ring at node %0d", i), r, q[hit].ring);
                            chk(q[hit].due == cyc, "R4", $sformatf("eject cycle at node %0d", i), cyc, q[hit].due);
                            q.delete(hit);
                        end
                    end
                end
            end
        end
    end

    function automatic logic [DW-1:0] pat(input int t, input int n);
        return {32'(t), 32'(n), 32'hA5C3_0000 + 32'(t * 16 + n), 32'(~(t * 97 + n))};
    endfunction

    initial begin
        // R1: reset state with a request pending
        inj_valid[0] = 1'b1;
        inj_dst[0]   = 4'd3;
        repeat (3) @(negedge clk);
        chk(ej_valid == '0, "R1", "eject valid in reset", ej_valid, 0);
        chk(inj_ready == '0, "R1", "ready in reset", inj_ready, 0);
        rst_n = 1'b1;
        #1;
        chk(inj_ready == '0, "R1", "ready first cycle", inj_ready, 0);
        inj_valid[0] = 1'b0;
        @(negedge clk);

        // R3: short routes each way
        arm(0, 3, pat(1, 0), 0, 1, 0, "R3");
        do_step();
        arm(0, 9, pat(2, 0), 0, 1, 0, "R3");
        do_step();
        drain();

        // R3: tie and neighbours both ways in one step
        arm(2, 8, pat(3, 2), 0, 1, 0, "R3");
        arm(5, 4, pat(3, 5), 0, 1, 0, "R3");
        arm(4, 5, pat(3, 4), 0, 1, 0, "R3");
        do_step();
        drain();

        // R8: invalid destinations
        arm(3, 3, pat(4, 3), 0, 1, 1, "R8");
        arm(6, 13, pat(4, 6), 0, 1, 1, "R8");
        do_step();
        drain();

        // R5 / R6: clockwise lane stacking and stall
        arm(0, 4, pat(5, 0), 0, 1, 0, "R5");
        do_step();
        arm(1, 5, pat(5, 1), 1, 1, 0, "R5");
        do_step();
        arm(2, 6, pat(5, 2), 0, 0, 0, "R6");
        do_step();
        arm(2, 6, pat(5, 2), 0, 1, 0, "R6");
        do_step();
        drain();

        // R5 / R6: counter-clockwise lane stacking and stall
        arm(0, 8, pat(6, 0), 0, 1, 0, "R5");
        do_step();
        arm(11, 7, pat(6, 11), 1, 1, 0, "R5");
        do_step();
        arm(10, 6, pat(6, 10), 0, 0, 0, "R6");
        do_step();
        arm(10, 6, pat(6, 10), 0, 1, 0, "R6");
        do_step();
        drain();

        // R9 / R6: all nodes, two waves; second reuses slots freed by delivery
        for (int n = 0; n < N; n++) arm(n, (n + 1) % N, pat(7, n), 0, 1, 0, "R9");
        do_step();
        for (int n = 0; n < N; n++) arm(n, (n + 2) % N, pat(8, n), 0, 1, 0, "R6");
        do_step();
        drain();

        // R9: all nodes counter-clockwise, crossing the wrap
        for (int n = 0; n < N; n++) arm(n, (n + 7) % N, pat(9, n), 0, 1, 0, "R9");
        do_step();
        drain();

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule